// File: doc/BRIEF.md
# Power-On and Low-Voltage Reset Sequencer

This block turns two supply-monitor flags into the internal reset of a small controller. It also drives the oscillator run enable, a low-voltage interrupt pulse and a phase status. It runs on a free-running timing clock. When the power-on flag drops, the block asserts reset at once. After the supply returns, it releases reset through timed stages: supply settling, power-on processing and, when low-voltage supervision is enabled, a low-voltage processing stage. That last stage needs the supply to sit above the detect level for a full window before reset lets go.

A two-bit mode input chooses how a later low-voltage event is handled. In reset mode (2'b11) it pulls the controller back into reset, and the low-voltage processing window runs again once the supply recovers. In interrupt mode (2'b01) the power-up sequence is the same, but a later low-voltage event only raises a one-cycle interrupt. With the other two codes, supervision is off and the low-voltage flag is ignored. All wait lengths are parameters counted in timing-clock cycles. Both flags pass through two-flop synchronisers. Reset asserts asynchronously and releases on a clock edge.

Top module: `pwr_rst_seq`

## Requirements
- R1: While `porOk` is low, `sysRst` is 1, `oscEn` is 0, `lvdIrq` is 0 and `phase` is 0, and a fall of `porOk` forces this state without waiting for a clock edge, from any phase.
- R2: After `porOk` rises it takes two clock edges to be synchronised. On the third edge `phase` becomes 1 and stays 1 for `STAB_CYC` cycles, then becomes 2 and stays 2 for `POR_CYC` cycles.
- R3: With `modeSel` 2'b11 or 2'b01, `phase` goes from 2 to 3 and stays at 3 until the synchronised `lvdOk` has been high for `LVD_CYC` consecutive cycles. Any low cycle restarts that window. `phase` then becomes 4.
- R4: With `modeSel` 2'b00 or 2'b10, `phase` goes straight from 2 to 4, whatever the value of `lvdOk`, and `lvdOk` has no effect afterwards.
- R5: In every phase other than 4, `sysRst` is 1 and `oscEn` is 0. In phase 4, `sysRst` is 0 and `oscEn` is 1.
- R6: With `modeSel` 2'b11 in phase 4, a low `lvdOk` brings `phase` to 3 and sets `sysRst` on the third clock edge after the fall. The R3 window then applies again.
- R7: With `modeSel` 2'b01 in phase 4, a fall of `lvdOk` gives exactly one cycle of `lvdIrq`, on the third clock edge after the fall. `sysRst` stays low, and a flag that stays low gives no further pulse.
- R8: `lvdIrq` is never 1 unless `modeSel` is 2'b01 and the block is in phase 4.
- R9: `phase` encodes power-off as 0, settling as 1, power-on processing as 2, low-voltage processing as 3 and run as 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running timing clock |
| porOk | input | 1 | Asynchronous power-on detect flag, 1 when the supply is above the power-on threshold |
| lvdOk | input | 1 | Asynchronous low-voltage detect flag, 1 when the supply is above the detect level |
| modeSel | input | 2 | Low-voltage handling: 2'b11 reset, 2'b01 interrupt, others off |
| sysRst | output | 1 | Internal reset, active high |
| oscEn | output | 1 | High-speed oscillator run enable |
| lvdIrq | output | 1 | One-cycle low-voltage interrupt pulse |
| phase | output | 3 | Current sequencer phase |

## Verification
Two events can land in the same cycle. One is an asynchronous fall of `porOk`, which must win over anything in progress. The other is a low-voltage response, either the reset return to phase 3 or the interrupt pulse. The bench drops `lvdOk` in run, in both modes, and pulls `porOk` low during the few cycles the flag is still in the synchroniser. A behavioural model, compared on every clock, checks that only the power-off state appears and that no interrupt pulse or phase-3 entry leaks out afterwards. A one-cycle glitch of `lvdOk` inside the low-voltage window is also timed to hit the counter's last cycles, to judge that the window restarts rather than completing.

// File: rtl/brsq_pkg.sv
`timescale 1ns/1ps
package brsq_pkg;
  typedef enum logic [2:0] {
    PH_OFF  = 3'd0,
    PH_STAB = 3'd1,
    PH_PORP = 3'd2,
    PH_LVDP = 3'd3,
    PH_RUN  = 3'd4
  } phase_e;

  typedef enum logic [1:0] {
    LD_STAB = 2'd0,
    LD_PORP = 2'd1,
    LD_LVDP = 2'd2
  } loadSel_e;

  typedef struct packed {
    logic     load;
    loadSel_e sel;
    logic     dec;
  } timerCmd_t;

  localparam logic [1:0] MODE_LVD_RST = 2'b11;
  localparam logic [1:0] MODE_LVD_INT = 2'b01;
endpackage

// File: rtl/brsq_sync.sv
`timescale 1ns/1ps
module brsq_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arstN,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge arstN) begin
        if (!arstN) chain <= '0;
        else        chain <= din;
      end
    end else begin : g_multi
      always_ff @(posedge clk or negedge arstN) begin
        if (!arstN) chain <= '0;
        else        chain <= {chain[STAGES-2:0], din};
      end
    end
  endgenerate

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/brsq_timer.sv
`timescale 1ns/1ps
module brsq_timer
  import brsq_pkg::*;
#(
  parameter int STAB_CYC = 64,
  parameter int POR_CYC  = 32,
  parameter int LVD_CYC  = 16
) (
  input  logic      clk,
  input  logic      arstN,
  input  timerCmd_t cmd,
  output logic      done
);
  localparam int MAX_AB = (STAB_CYC > POR_CYC) ? STAB_CYC : POR_CYC;
  localparam int MAXC   = (MAX_AB > LVD_CYC) ? MAX_AB : LVD_CYC;
  localparam int CW     = $clog2(MAXC + 1);

  logic [CW-1:0] cnt;
  logic [CW-1:0] loadVal;

  always_comb begin
    unique case (cmd.sel)
      LD_STAB: loadVal = CW'(STAB_CYC - 1);
      LD_PORP: loadVal = CW'(POR_CYC - 1);
      default: loadVal = CW'(LVD_CYC - 1);
    endcase
  end

  always_ff @(posedge clk or negedge arstN) begin
    if (!arstN)        cnt <= '0;
    else if (cmd.load) cnt <= loadVal;
    else if (cmd.dec)  cnt <= cnt - CW'(1);
  end

  assign done = (cnt == '0);

  // R2
  no_underflow_chk: assert property (@(posedge clk) disable iff (!arstN)
    (cmd.dec && !cmd.load) |-> (cnt != '0));
endmodule

// File: rtl/brsq_ctrl.sv
`timescale 1ns/1ps
module brsq_ctrl
  import brsq_pkg::*;
(
  input  logic       clk,
  input  logic       arstN,
  input  logic       porS,
  input  logic       lvdS,
  input  logic [1:0] modeSel,
  input  logic       done,
  output timerCmd_t  cmd,
  output logic       sysRst,
  output logic       oscEn,
  output logic       lvdIrq,
  output logic [2:0] phase
);
  phase_e st, nx;
  logic   lvdPrev, rstQ, oscQ, irqQ;
  logic   rstMode, intMode, lvdOn;

  assign rstMode = (modeSel == MODE_LVD_RST);
  assign intMode = (modeSel == MODE_LVD_INT);
  assign lvdOn   = rstMode | intMode;

  always_comb begin
    nx       = st;
    cmd.load = 1'b0;
    cmd.sel  = LD_STAB;
    cmd.dec  = 1'b0;
    unique case (st)
      PH_OFF: begin
        if (porS) begin
          nx       = PH_STAB;
          cmd.load = 1'b1;
          cmd.sel  = LD_STAB;
        end
      end
      PH_STAB: begin
        if (done) begin
          nx       = PH_PORP;
          cmd.load = 1'b1;
          cmd.sel  = LD_PORP;
        end else begin
          cmd.dec = 1'b1;
        end
      end
      PH_PORP: begin
        if (done) begin
          if (lvdOn) begin
            nx       = PH_LVDP;
            cmd.load = 1'b1;
            cmd.sel  = LD_LVDP;
          end else begin
            nx = PH_RUN;
          end
        end else begin
          cmd.dec = 1'b1;
        end
      end
      PH_LVDP: begin
        if (!lvdS) begin
          cmd.load = 1'b1;
          cmd.sel  = LD_LVDP;
        end else if (done) begin
          nx = PH_RUN;
        end else begin
          cmd.dec = 1'b1;
        end
      end
      PH_RUN: begin
        if (rstMode && !lvdS) begin
          nx       = PH_LVDP;
          cmd.load = 1'b1;
          cmd.sel  = LD_LVDP;
        end
      end
      default: nx = PH_OFF;
    endcase
  end

  always_ff @(posedge clk or negedge arstN) begin
    if (!arstN) begin
      st      <= PH_OFF;
      rstQ    <= 1'b1;
      oscQ    <= 1'b0;
      irqQ    <= 1'b0;
      lvdPrev <= 1'b0;
    end else begin
      st      <= nx;
      rstQ    <= (nx != PH_RUN);
      oscQ    <= (nx == PH_RUN);
      irqQ    <= (st == PH_RUN) && intMode && lvdPrev && !lvdS;
      lvdPrev <= lvdS;
    end
  end

  assign sysRst = rstQ;
  assign oscEn  = oscQ;
  assign lvdIrq = irqQ;
  assign phase  = st;

  // R5
  run_outputs_chk: assert property (@(posedge clk) disable iff (!arstN)
    (st == PH_RUN) |-> (!rstQ && oscQ));
  // R5
  hold_outputs_chk: assert property (@(posedge clk) disable iff (!arstN)
    (st != PH_RUN) |-> (rstQ && !oscQ));
  // R8
  irq_mode_chk: assert property (@(posedge clk) disable iff (!arstN)
    irqQ |-> (intMode && st == PH_RUN));
  // R7
  irq_single_chk: assert property (@(posedge clk) disable iff (!arstN)
    irqQ |=> !irqQ);
  // R7
  int_no_rst_chk: assert property (@(posedge clk) disable iff (!arstN)
    (st == PH_RUN && intMode && !lvdS) |=> (st == PH_RUN));
  // R6
  lvd_rst_chk: assert property (@(posedge clk) disable iff (!arstN)
    (st == PH_RUN && rstMode && !lvdS) |=> (st == PH_LVDP && rstQ));
  // R3
  lvd_hold_chk: assert property (@(posedge clk) disable iff (!arstN)
    (st == PH_LVDP && !lvdS) |=> (st == PH_LVDP));
  // R2
  stab_hold_chk: assert property (@(posedge clk) disable iff (!arstN)
    (st == PH_STAB && !done) |=> (st == PH_STAB));
endmodule

// File: rtl/pwr_rst_seq.sv
`timescale 1ns/1ps
module pwr_rst_seq
  import brsq_pkg::*;
#(
  parameter int STAB_CYC    = 64,
  parameter int POR_CYC     = 32,
  parameter int LVD_CYC     = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       porOk,
  input  logic       lvdOk,
  input  logic [1:0] modeSel,
  output logic       sysRst,
  output logic       oscEn,
  output logic       lvdIrq,
  output logic [2:0] phase
);
  logic      porS, lvdS, done;
  timerCmd_t cmd;

  brsq_sync #(.STAGES(SYNC_STAGES)) porSync_i (
    .clk(clk), .arstN(porOk), .din(1'b1), .dout(porS));

  brsq_sync #(.STAGES(SYNC_STAGES)) lvdSync_i (
    .clk(clk), .arstN(porOk), .din(lvdOk), .dout(lvdS));

  brsq_timer #(.STAB_CYC(STAB_CYC), .POR_CYC(POR_CYC), .LVD_CYC(LVD_CYC)) timer_i (
    .clk(clk), .arstN(porOk), .cmd(cmd), .done(done));

  brsq_ctrl ctrl_i (
    .clk(clk), .arstN(porOk), .porS(porS), .lvdS(lvdS), .modeSel(modeSel),
    .done(done), .cmd(cmd), .sysRst(sysRst), .oscEn(oscEn), .lvdIrq(lvdIrq),
    .phase(phase));
endmodule

// File: tb/pwr_rst_seq_tb_top.sv
`timescale 1ns/1ps
module pwr_rst_seq_tb_top;
  localparam int STAB = 64;
  localparam int PORC = 32;
  localparam int LVDC = 16;

  logic       clk = 1'b0;
  logic       porOk = 1'b0;
  logic       lvdOk = 1'b0;
  logic [1:0] modeSel = 2'b11;
  logic       sysRst, oscEn, lvdIrq;
  logic [2:0] phase;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  // model state
  int mPh = 0;
  int mCnt = 0;
  bit p1 = 0, p2 = 0, l1 = 0, l2 = 0, lPrev = 0;
  bit mRst = 1, mOsc = 0, mIrq = 0;

  pwr_rst_seq #(.STAB_CYC(STAB), .POR_CYC(PORC), .LVD_CYC(LVDC)) dut_i (
    .clk(clk), .porOk(porOk), .lvdOk(lvdOk), .modeSel(modeSel),
    .sysRst(sysRst), .oscEn(oscEn), .lvdIrq(lvdIrq), .phase(phase));

  always #4 clk = ~clk;

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d t=%0t", req, what, act, exp, $time);
    end
  endtask

  // behavioural reference
  always @(posedge clk or negedge porOk) begin
    if (!porOk) begin
      p1 = 0; p2 = 0; l1 = 0; l2 = 0; lPrev = 0;
      mPh = 0; mCnt = 0; mRst = 1; mOsc = 0; mIrq = 0;
    end else begin
      bit lvdOn;
      lvdOn = (modeSel == 2'b11) || (modeSel == 2'b01);
      mIrq  = (mPh == 4) && (modeSel == 2'b01) && lPrev && !l2;
      lPrev = l2;
      if (mPh == 0) begin
        if (p2) begin mPh = 1; mCnt = STAB - 1; end
      end else if (mPh == 1) begin
        if (mCnt == 0) begin mPh = 2; mCnt = PORC - 1; end else mCnt--;
      end else if (mPh == 2) begin
        if (mCnt == 0) begin
          if (lvdOn) begin mPh = 3; mCnt = LVDC - 1; end else mPh = 4;
        end else mCnt--;
      end else if (mPh == 3) begin
        if (!l2) mCnt = LVDC - 1;
        else if (mCnt == 0) mPh = 4;
        else mCnt--;
      end else begin
        if (modeSel == 2'b11 && !l2) begin mPh = 3; mCnt = LVDC - 1; end
      end
      p2 = p1; p1 = 1;
      l2 = l1; l1 = lvdOk;
      mRst = (mPh != 4);
      mOsc = (mPh == 4);
    end
  end

  // per-cycle comparison
  always @(negedge clk) begin
    chk("R5", "sysRst", sysRst, mRst);
    chk("R5", "oscEn", oscEn, mOsc);
    chk("R9", "phase", phase, mPh);
    chk(modeSel == 2'b01 ? "R7" : "R8", "lvdIrq", lvdIrq, mIrq);
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=0", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic waitNeg(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic setAt(input int n, ref logic sig, input logic v);
    waitNeg(n); #1 sig = v;
  endtask

  initial begin
    // R1: reset state with supply off
    waitNeg(5);
    chk("R1", "sysRst off", sysRst, 1);
    chk("R1", "oscEn off", oscEn, 0);
    chk("R1", "phase off", phase, 0);

    // mode 11, supply steady, power up
    modeSel = 2'b11; lvdOk = 1'b1;
    #1 porOk = 1'b1;
    waitNeg(2);  chk("R2", "phase sync", phase, 0);
    waitNeg(1);  chk("R2", "phase stab start", phase, 1);
    waitNeg(63); chk("R2", "phase stab end", phase, 1);
    waitNeg(1);  chk("R2", "phase por start", phase, 2);
    waitNeg(31); chk("R2", "phase por end", phase, 2);
    waitNeg(1);  chk("R3", "phase lvd start", phase, 3);
    waitNeg(15); chk("R3", "sysRst lvd end", sysRst, 1);
    waitNeg(1);  chk("R3", "phase run", phase, 4);
    chk("R5", "oscEn run", oscEn, 1);
    waitNeg(10);

    // R6: brown-out in reset mode
    #1 lvdOk = 1'b0;
    waitNeg(2); chk("R6", "phase before", phase, 4);
    waitNeg(1); chk("R6", "phase after", phase, 3);
    chk("R6", "sysRst after", sysRst, 1);
    chk("R8", "no irq reset mode", lvdIrq, 0);
    waitNeg(20);
    #1 lvdOk = 1'b1;
    waitNeg(17); chk("R6", "still lvd", phase, 3);
    waitNeg(1);  chk("R6", "back run", phase, 4);
    waitNeg(5);

    // R3: glitch late in window restarts it
    #1 lvdOk = 1'b0;
    waitNeg(10);
    #1 lvdOk = 1'b1;
    waitNeg(14);
    #1 lvdOk = 1'b0;
    waitNeg(1);
    #1 lvdOk = 1'b1;
    waitNeg(6); chk("R3", "window restarted", phase, 3);
    waitNeg(30); chk("R3", "run after restart", phase, 4);

    // R1: supply loss in run, immediate
    #1 lvdOk = 1'b0;
    waitNeg(1);
    #1 porOk = 1'b0;
    #1;
    chk("R1", "sysRst async", sysRst, 1);
    chk("R1", "oscEn async", oscEn, 0);
    chk("R1", "phase async", phase, 0);
    waitNeg(4);
    chk("R1", "phase held off", phase, 0);

    // interrupt mode, lvd low at power-up
    modeSel = 2'b01; lvdOk = 1'b0;
    #1 porOk = 1'b1;
    waitNeg(130); chk("R3", "int mode waits", phase, 3);
    #1 lvdOk = 1'b1;
    waitNeg(20); chk("R3", "int mode run", phase, 4);
    waitNeg(5);
    #1 lvdOk = 1'b0;
    waitNeg(2); chk("R7", "irq not yet", lvdIrq, 0);
    waitNeg(1); chk("R7", "irq pulse", lvdIrq, 1);
    chk("R7", "no reset", sysRst, 0);
    waitNeg(1); chk("R7", "irq ends", lvdIrq, 0);
    waitNeg(20); chk("R7", "still run", phase, 4);
    #1 lvdOk = 1'b1;
    waitNeg(6);
    #1 lvdOk = 1'b0;
    waitNeg(3); chk("R7", "second pulse", lvdIrq, 1);
    waitNeg(10);
    // supply loss while the fall is still in the synchroniser
    #1 lvdOk = 1'b1;
    waitNeg(6);
    #1 lvdOk = 1'b0;
    waitNeg(1);
    #1 porOk = 1'b0;
    waitNeg(5); chk("R1", "no irq after loss", lvdIrq, 0);

    // R4: supervision off, lvd low ignored
    modeSel = 2'b00; lvdOk = 1'b0;
    #1 porOk = 1'b1;
    waitNeg(98); chk("R4", "por end", phase, 2);
    waitNeg(1);  chk("R4", "run direct", phase, 4);
    #1 lvdOk = 1'b1;
    waitNeg(5);
    #1 lvdOk = 1'b0;
    waitNeg(10); chk("R4", "lvd ignored", phase, 4);
    chk("R4", "no irq", lvdIrq, 0);

    // supply loss during settling, mode 10
    #1 porOk = 1'b0;
    modeSel = 2'b10;
    waitNeg(3);
    #1 porOk = 1'b1;
    waitNeg(20);
    #1 porOk = 1'b0;
    #1 chk("R1", "loss in stab", phase, 0);
    waitNeg(3);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule